// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is an up counter built from 4-bit slices whose state bits all change together on the rising clock edge. A low level on the synchronous clear input zeroes the count at the next edge. A low level on the synchronous load input copies the parallel data bus into the count at the next edge. Both of these take effect whatever the two enables are doing. The count advances by one only when both the local count enable and the chain enable are high. The chain enable also qualifies the terminal-count carry output.

Inside the top module, the slices are chained. Each slice's carry drives the chain enable of the slice above it, and every slice shares the local count enable. The whole chain therefore behaves as one synchronous counter of 4·STAGES bits. Its own carry output can feed the chain enable of a further counter without extra gating. A shorter count cycle is made by decoding the chosen last value outside the block and driving the clear input low from that decode.

Top module: `cascade_counter`

## Requirements
- R1: Every bit of count_q updates only at a rising edge of clk. Between edges count_q stays stable.
- R2: When sync_clr_n is 0 at a rising edge, count_q becomes 0 at that edge, whatever cnt_en and chain_en are.
- R3: When sync_ld_n is 0 and sync_clr_n is 1 at a rising edge, count_q takes data_in, whatever cnt_en and chain_en are. Any value of the full range is accepted.
- R4: When sync_clr_n and sync_ld_n are both 0 at the same edge, clear wins and count_q becomes 0.
- R5: With both controls at 1 and cnt_en = chain_en = 1, count_q increments by one per edge. From the all-ones value it wraps to 0.
- R6: With both controls at 1 and either cnt_en or chain_en at 0, count_q holds its value.
- R7: carry_o is 1 exactly while count_q is all ones and chain_en is 1. It follows those inputs in the same cycle with no register, and cnt_en has no effect on it.
- R8: An upper 4-bit slice advances only when every lower slice is at 15, so a 0x0F count steps to 0x10. The chain acts as a single counter of 4·STAGES bits.
- R9: When sync_clr_n is driven low from an outside decode of the value 9, the counter repeats the sequence 0..9 (modulus 10).
- R10: Pulses on cnt_en, chain_en or sync_ld_n that come and go between two rising edges leave count_q unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| sync_clr_n | input | 1 | Synchronous clear, active low; highest priority |
| sync_ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all slices; does not affect carry_o |
| chain_en | input | 1 | Count enable fed forward to qualify carry_o |
| data_in | input | 4·STAGES | Parallel preset value |
| count_q | output | 4·STAGES | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
Clear, load, increment and hold all show on count_q one rising edge after the inputs that select them. carry_o is combinational and is due in the same cycle as the count and chain_en that produce it. The bench drives inputs on the falling edge and checks carry_o 1 ns later, against the model value that the previous rising edge set. It queues the count expected after the coming rising edge, and the monitor compares that entry 2 ns after the edge. The between-edge pulse and the decoded-clear sequences use the same queue, so each result is checked in exactly the cycle in which it is due.

// File: rtl/cascade_counter_pkg.sv
// Package: shared constants and types for the cascadable counter.
// Assumes: slices are always 4 bits wide; the width of a chain is set by the
// number of slices.
package cascade_counter_pkg;

    localparam int SLICE_W = 4;

    // Operation that a slice performs at the next rising edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_e;

endpackage

// File: rtl/ctr_op_decode.sv
// Module: ctr_op_decode
// Picks the slice operation for the coming edge from the control pins.
// Priority is clear over load over increment over hold.
// Assumes: all inputs are synchronous to the slice clock.
module ctr_op_decode
    import cascade_counter_pkg::*;
(
    input  logic      clr_n,
    input  logic      ld_n,
    input  logic      cnt_en,
    input  logic      chain_en,
    output slice_op_e op
);

    // Purpose: priority decode of the four operations.
    always_comb begin
        if (!clr_n)                  op = OP_CLEAR;
        else if (!ld_n)              op = OP_LOAD;
        else if (cnt_en && chain_en) op = OP_INC;
        else                         op = OP_HOLD;
    end

endmodule

// File: rtl/ctr_terminal_detect.sv
// Module: ctr_terminal_detect
// Raises the slice carry while the stored value is all ones and the chain
// enable is high. Purely combinational, so a cascade resolves within one cycle.
// Assumes: the count enable does not take part in carry generation.
module ctr_terminal_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         chain_en,
    output logic         carry
);

    // Purpose: AND-reduce the value and qualify it with the chain enable.
    always_comb begin
        carry = chain_en && (&q);
    end

endmodule

// File: rtl/ctr_slice.sv
// Module: ctr_slice
// One counter slice: state register, next-value selection and carry.
// Assumes: clear is synchronous and also acts as the reset of the slice.
module ctr_slice
    import cascade_counter_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         cnt_en,
    input  logic         chain_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         carry
);

    slice_op_e    op;
    logic [W-1:0] q_nxt;

    ctr_op_decode u_dec (
        .clr_n    (clr_n),
        .ld_n     (ld_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    // Purpose: form the next value from the decoded operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = d;
            OP_INC:   q_nxt = q + W'(1);
            default:  q_nxt = q;
        endcase
    end

    // Purpose: update every state bit together on the rising edge.
    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

    ctr_terminal_detect #(.W(W)) u_term (
        .q        (q),
        .chain_en (chain_en),
        .carry    (carry)
    );

endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter
// Chain of STAGES 4-bit slices forming one synchronous counter. Every slice
// shares cnt_en. Each slice's carry drives the chain enable of the slice above.
// Assumes: STAGES >= 1; the data bus and count are little-endian by slice.
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                      clk,
    input  logic                      sync_clr_n,
    input  logic                      sync_ld_n,
    input  logic                      cnt_en,
    input  logic                      chain_en,
    input  logic [SLICE_W*STAGES-1:0] data_in,
    output logic [SLICE_W*STAGES-1:0] count_q,
    output logic                      carry_o
);

    localparam int TOTAL_W = SLICE_W * STAGES;

    logic [STAGES:0] link;

    assign link[0] = chain_en;

    for (genvar s = 0; s < STAGES; s++) begin : g_slice
        ctr_slice #(.W(SLICE_W)) u_slice (
            .clk      (clk),
            .clr_n    (sync_clr_n),
            .ld_n     (sync_ld_n),
            .cnt_en   (cnt_en),
            .chain_en (link[s]),
            .d        (data_in[s*SLICE_W +: SLICE_W]),
            .q        (count_q[s*SLICE_W +: SLICE_W]),
            .carry    (link[s+1])
        );
    end

    assign carry_o = link[STAGES];

endmodule

// File: rtl/cascade_counter_chk.sv
// Module: cascade_counter_chk
// Property checker bound to cascade_counter; watches only the top-level ports.
// Assumes: the environment holds sync_clr_n low at the first clock edge.
module cascade_counter_chk #(
    parameter int STAGES = 2
) (
    input logic                  clk,
    input logic                  sync_clr_n,
    input logic                  sync_ld_n,
    input logic                  cnt_en,
    input logic                  chain_en,
    input logic [4*STAGES-1:0]   data_in,
    input logic [4*STAGES-1:0]   count_q,
    input logic                  carry_o
);

    localparam int W = 4 * STAGES;

    assert_clear_R2: assert property (@(posedge clk)
        !sync_clr_n |=> (count_q == '0));

    assert_clear_over_load_R4: assert property (@(posedge clk)
        (!sync_clr_n && !sync_ld_n) |=> (count_q == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (!sync_clr_n)
        !sync_ld_n |=> (count_q == $past(data_in)));

    assert_count_R5: assert property (@(posedge clk) disable iff (!sync_clr_n)
        (sync_ld_n && cnt_en && chain_en) |=> (count_q == W'($past(count_q) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!sync_clr_n)
        (sync_ld_n && !(cnt_en && chain_en)) |=> $stable(count_q));

    assert_carry_gated_R7: assert property (@(posedge clk) disable iff (!sync_clr_n)
        !chain_en |-> !carry_o);

    assert_carry_terminal_R7: assert property (@(posedge clk) disable iff (!sync_clr_n)
        carry_o |-> (&count_q));

endmodule

bind cascade_counter cascade_counter_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .sync_clr_n (sync_clr_n),
    .sync_ld_n  (sync_ld_n),
    .cnt_en     (cnt_en),
    .chain_en   (chain_en),
    .data_in    (data_in),
    .count_q    (count_q),
    .carry_o    (carry_o)
);

// File: tb/cascade_counter_tb_top.sv
// Scoreboard bench: the driver queues the expected count for each edge and the
// monitor pops and compares after that edge. carry_o is checked combinationally.
module cascade_counter_tb_top;

    localparam int STAGES = 2;
    localparam int W      = 4 * STAGES;
    localparam logic [W-1:0] ALL1 = '1;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         sync_clr_n = 1'b0;
    logic         sync_ld_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] count_q;
    logic         carry_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] model_q = '0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    cascade_counter #(.STAGES(STAGES)) dut_i (
        .clk        (clk),
        .sync_clr_n (sync_clr_n),
        .sync_ld_n  (sync_ld_n),
        .cnt_en     (cnt_en),
        .chain_en   (chain_en),
        .data_in    (data_in),
        .count_q    (count_q),
        .carry_o    (carry_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model of the next count, from the requirements.
    function automatic logic [W-1:0] next_of(input logic c, input logic l, input logic e,
                                             input logic ch, input logic [W-1:0] d,
                                             input logic [W-1:0] q);
        if (!c)            return '0;
        else if (!l)       return d;
        else if (e && ch)  return q + W'(1);
        else               return q;
    endfunction

    // Drive one cycle's inputs, check carry_o now, queue the count due after the edge.
    task automatic step(input logic c, input logic l, input logic e, input logic ch,
                        input logic [W-1:0] d, input string req);
        item_t it;
        @(negedge clk);
        sync_clr_n = c; sync_ld_n = l; cnt_en = e; chain_en = ch; data_in = d;
        #1;
        check({req, " carry R7"}, W'(carry_o), W'(ch && (model_q == ALL1)));
        model_q = next_of(c, l, e, ch, d, model_q);
        it.exp = model_q;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the count after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.req, count_q, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R2: reset state via clear, enables high
        step(0, 1, 1, 1, 8'h33, "R2 clear reset");
        step(0, 1, 1, 1, 8'h33, "R2 clear with enables");
        // R3: load with enables low and high
        step(1, 0, 0, 0, 8'hA5, "R3 load enables low");
        step(1, 0, 1, 1, 8'h5A, "R3 load enables high");
        step(1, 0, 0, 1, ALL1,  "R3 load all ones");
        // R4: clear beats load
        step(0, 0, 1, 1, 8'h77, "R4 clear over load");
        // R5/R8: count across slice boundary
        step(1, 0, 0, 0, 8'h0D, "R3 preset 0D");
        step(1, 1, 1, 1, 8'h00, "R5 count to 0E");
        step(1, 1, 1, 1, 8'h00, "R5 count to 0F");
        step(1, 1, 1, 1, 8'h00, "R8 cascade 0F->10");
        step(1, 1, 1, 1, 8'h00, "R8 upper slice holds");
        // R7/R6: carry gating near all ones
        step(1, 0, 0, 0, 8'hFE, "R3 preset FE");
        step(1, 1, 1, 1, 8'h00, "R5 count to FF");
        step(1, 1, 1, 0, 8'h00, "R6 hold chain_en low");
        step(1, 1, 0, 1, 8'h00, "R7 cnt_en low carry high");
        step(1, 1, 1, 1, 8'h00, "R5 wrap to 00");
        // R6: hold with cnt_en low and both low
        step(1, 1, 0, 1, 8'h00, "R6 hold cnt_en low");
        step(1, 1, 0, 0, 8'h00, "R6 hold both low");
        // R10: pulses between edges
        for (int k = 0; k < 3; k++) begin
            item_t it;
            @(negedge clk);
            sync_clr_n = 1; sync_ld_n = 1; cnt_en = 0; chain_en = 0;
            #1; cnt_en = 1; chain_en = 1; sync_ld_n = 0; data_in = 8'hC3;
            #1; check("R1 stable between edges", count_q, model_q);
            cnt_en = 0; chain_en = 0; sync_ld_n = 1;
            it.exp = model_q;
            it.req = "R10 between-edge pulse";
            sb_q.push_back(it);
        end
        // R9: modulus 10 by decoding 9 into clear
        step(0, 1, 1, 1, 8'h00, "R2 clear before mod10");
        for (int k = 0; k < 25; k++) begin
            item_t it;
            @(negedge clk);
            sync_ld_n = 1; cnt_en = 1; chain_en = 1;
            sync_clr_n = !(count_q == 8'd9);
            #1;
            check("R9 carry low in mod10", W'(carry_o), '0);
            model_q = (model_q == 8'd9) ? '0 : model_q + W'(1);
            it.exp = model_q;
            it.req = "R9 mod10 sequence";
            sb_q.push_back(it);
        end
        // R5: long count run
        step(1, 0, 0, 0, 8'hF8, "R3 preset F8");
        for (int k = 0; k < 12; k++) step(1, 1, 1, 1, 8'h00, "R5 run through wrap");
        step(1, 1, 0, 0, 8'h00, "R6 final hold");
        repeat (2) @(posedge clk);
        #3;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule